// File: doc/BRIEF.md
# Two-Wire Master Clock Timing Generator

This block paces the clock line of a two-wire bus master. It does not divide the system clock itself. Its timing is measured in overflow pulses from one of four timer sources outside the block, chosen by a 2-bit select. The pin is driven only as an open-drain pull-low request, and the block reads the line back through a synchronizer. This lets it detect a slave that stretches the low phase and a competing master that pulls the line low early. The high phase is counted from the first overflow after the line is actually seen high. With no stretching, each bit therefore takes three overflow periods: one period low and about two periods high.

A single-cycle bit strobe marks each falling edge the block drives, so the shift logic can move the data line while the clock is low. When the master is not running, the same overflow source can time a free-bus check. This check reports a bus that has stayed high long enough to be treated as free. A small gate also passes or blocks slave events coming from the address and shift logic. A slave-inhibit setting takes effect only at the next START, and while it is in force every address is refused.

Top module: `smb_scl_gen`

## Requirements
- R1: `src_sel` picks the overflow input that times every phase: code 0 uses `ovf_src[0]` (timer 0), 1 uses `ovf_src[1]` (timer 1), 2 uses `ovf_src[2]` (timer 2 high byte), 3 uses `ovf_src[3]` (timer 2 low byte). The other three inputs have no effect.
- R2: After a falling edge that the block itself starts at an overflow, `scl_pull_low` stays high for exactly LOW_OVF overflow periods, and it is released only on a selected overflow.
- R3: The high phase starts counting at the first selected overflow after the synchronized line is seen high, and then lasts HIGH_OVF more overflows. With the defaults (LOW_OVF=1, HIGH_OVF=1) and no stretching, consecutive `bit_strobe` pulses are 3 overflow periods apart.
- R4: If another device holds the line low after release, the block waits for the line to go high. A hold of 1.5 periods stretches the bit to 4 periods.
- R5: If the line is pulled low by another device during the high phase, the block asserts `scl_pull_low` within 3 cycles and restarts its low phase. It does not pulse `bit_strobe` for that edge.
- R6: `bit_strobe` is a one-cycle pulse. It is asserted in the same cycle that `scl_pull_low` rises for a falling edge the block drives.
- R7: While `mst_run` and `free_to_en` are both low, overflow pulses are ignored: `scl_pull_low` and `bus_free` stay 0.
- R8: While the master is idle and `free_to_en` is high, `bus_free` sets after FREE_OVF selected overflows with the line high. It clears once the line is seen low.
- R9: While `en` is low, the next clock leaves `scl_pull_low`, `bit_strobe`, `slv_evt_out` and `addr_nack` all 0, and the block returns to idle.
- R10: `slv_inhibit` is captured only at a `start_det` pulse. Slave events are passed to `slv_evt_out` (one cycle later) until a START that captures inhibit = 1. After that they are blocked until a START that captures inhibit = 0.
- R11: While a captured inhibit is in force, `addr_nack` is 1 so that every received address is refused.
- R12: If `mst_run` is low when a high phase completes, the block goes idle with the line released and drives no further falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Interface enable |
| mst_run | input | 1 | Master wants clock cycles generated |
| free_to_en | input | 1 | Enable the free-bus high timeout |
| slv_inhibit | input | 1 | Request to inhibit slave events from the next START |
| src_sel | input | 2 | Overflow source select |
| ovf_src | input | 4 | Single-cycle overflow strobes of the four timer sources |
| scl_in | input | 1 | Raw clock line level (asynchronous) |
| start_det | input | 1 | START condition detected on the bus (pulse) |
| slv_evt | input | 1 | Slave event from the address/shift logic (pulse) |
| scl_pull_low | output | 1 | Open-drain request to drive the clock line low |
| bit_strobe | output | 1 | Pulse at each falling edge the block drives |
| bus_free | output | 1 | Line has been high for FREE_OVF overflows while idle |
| slv_evt_out | output | 1 | Slave event passed through the inhibit gate |
| addr_nack | output | 1 | Force NACK of received addresses |

## Verification
The assertions assume that each overflow input is a single-cycle strobe in the system clock domain. They also assume that a slave event never arrives in the same cycle as a START. The bench drives each overflow line with a fixed period drawn at random between 10 and 20 cycles, so that the synchronizer delay and a one-and-a-half-period stretch always fit inside a phase. It changes its inputs only on the falling clock edge. It models the bus as a wired-AND of the block's pull-low and its own hold. Its slave pulses are kept apart from its START pulses.

// File: rtl/smb_scl_pkg.sv
package smb_scl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_REL,
    ST_ARM,
    ST_HIGH
  } scl_state_e;
endpackage

// File: rtl/smb_scl_sync.sv
module smb_scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= 1'b1;
        else if (i == 0) chain_q[i] <= d_in;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/smb_scl_fsm.sv
module smb_scl_fsm
  import smb_scl_pkg::*;
#(
  parameter int LOW_OVF  = 1,
  parameter int HIGH_OVF = 1,
  parameter int FREE_OVF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic mst_run,
  input  logic free_to_en,
  input  logic ovf,
  input  logic scl_s,
  output logic scl_pull_low,
  output logic bit_strobe,
  output logic bus_free
);
  localparam int MAXC = (LOW_OVF > HIGH_OVF) ?
                        ((LOW_OVF > FREE_OVF) ? LOW_OVF : FREE_OVF) :
                        ((HIGH_OVF > FREE_OVF) ? HIGH_OVF : FREE_OVF);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_OVF - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_OVF - 1);
  localparam logic [CW-1:0] FREE_LAST = CW'(FREE_OVF - 1);

  scl_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] free_cnt_q;
  logic          drv_q, stb_q, free_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      free_cnt_q <= '0;
      drv_q      <= 1'b0;
      stb_q      <= 1'b0;
      free_q     <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (mst_run) begin
            state_q    <= ST_LOW;
            drv_q      <= 1'b1;
            stb_q      <= 1'b1;
            cnt_q      <= '0;
            free_q     <= 1'b0;
            free_cnt_q <= '0;
          end else if (!free_to_en || !scl_s) begin
            free_cnt_q <= '0;
            free_q     <= 1'b0;
          end else if (ovf && !free_q) begin
            if (free_cnt_q == FREE_LAST) free_q <= 1'b1;
            else free_cnt_q <= free_cnt_q + 1'b1;
          end
        end
        ST_LOW: begin
          if (ovf) begin
            if (cnt_q == LOW_LAST) begin
              state_q <= ST_REL;
              drv_q   <= 1'b0;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_REL: begin
          if (scl_s) state_q <= ST_ARM;
        end
        ST_ARM: begin
          if (!scl_s) begin
            state_q <= ST_LOW;
            drv_q   <= 1'b1;
            cnt_q   <= '0;
          end else if (ovf) begin
            state_q <= ST_HIGH;
            cnt_q   <= '0;
          end
        end
        ST_HIGH: begin
          if (!scl_s) begin
            state_q <= ST_LOW;
            drv_q   <= 1'b1;
            cnt_q   <= '0;
          end else if (ovf) begin
            if (cnt_q == HIGH_LAST) begin
              cnt_q <= '0;
              if (mst_run) begin
                state_q <= ST_LOW;
                drv_q   <= 1'b1;
                stb_q   <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_pull_low = drv_q;
  assign bit_strobe   = stb_q;
  assign bus_free     = free_q;

  AST_LOW_ENDS_ON_OVF: assert property (@(posedge clk) disable iff (rst)
    ($fell(drv_q) && $past(en) && !$past(rst)) |-> $past(ovf)); // R2
  AST_STROBE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    stb_q |-> (drv_q && $rose(drv_q))); // R6
  AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!drv_q && !stb_q)); // R9
  AST_FREE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    free_q |-> !drv_q); // R8
endmodule

// File: rtl/smb_slave_gate.sv
module smb_slave_gate (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic slv_inhibit,
  input  logic start_det,
  input  logic slv_evt,
  output logic slv_evt_out,
  output logic addr_nack
);
  logic inh_q, evt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      inh_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      if (start_det) inh_q <= slv_inhibit;
      evt_q <= slv_evt && !inh_q;
    end
  end

  assign slv_evt_out = evt_q;
  assign addr_nack   = inh_q;

  AST_NO_EVT_WHILE_INH: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> !inh_q); // R10
  AST_EVT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> $past(en)); // R9
  AST_NACK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (inh_q && en && !start_det) |=> inh_q); // R11
endmodule

// File: rtl/smb_scl_gen.sv
module smb_scl_gen #(
  parameter int NUM_SRC  = 4,
  parameter int SEL_W    = $clog2(NUM_SRC),
  parameter int SYNC_STG = 2,
  parameter int LOW_OVF  = 1,
  parameter int HIGH_OVF = 1,
  parameter int FREE_OVF = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mst_run,
  input  logic             free_to_en,
  input  logic             slv_inhibit,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [NUM_SRC-1:0] ovf_src,
  input  logic             scl_in,
  input  logic             start_det,
  input  logic             slv_evt,
  output logic             scl_pull_low,
  output logic             bit_strobe,
  output logic             bus_free,
  output logic             slv_evt_out,
  output logic             addr_nack
);
  logic ovf_sel;
  logic scl_s;

  assign ovf_sel = ovf_src[src_sel];

  smb_scl_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d_in(scl_in), .d_out(scl_s)
  );

  smb_scl_fsm #(
    .LOW_OVF(LOW_OVF), .HIGH_OVF(HIGH_OVF), .FREE_OVF(FREE_OVF)
  ) u_fsm (
    .clk(clk), .rst(rst), .en(en), .mst_run(mst_run),
    .free_to_en(free_to_en), .ovf(ovf_sel), .scl_s(scl_s),
    .scl_pull_low(scl_pull_low), .bit_strobe(bit_strobe), .bus_free(bus_free)
  );

  smb_slave_gate u_gate (
    .clk(clk), .rst(rst), .en(en), .slv_inhibit(slv_inhibit),
    .start_det(start_det), .slv_evt(slv_evt),
    .slv_evt_out(slv_evt_out), .addr_nack(addr_nack)
  );

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (!mst_run && !free_to_en && !scl_pull_low) |=> !bit_strobe); // R7
endmodule

// File: tb/smb_scl_gen_tb.sv
module smb_scl_gen_tb_top;
  localparam int FREE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, mst_run = 1'b0, free_to_en = 1'b0, slv_inhibit = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic [3:0] ovf_src = 4'd0;
  logic start_det = 1'b0, slv_evt = 1'b0, hold = 1'b0;
  logic scl_in;
  logic scl_pull_low, bit_strobe, bus_free, slv_evt_out, addr_nack;

  int per [4];
  int oc  [4];
  int n_chk = 0, n_err = 0;
  int cyc = 0, nstb = 0, last_stb = 0, prev_stb = 0, run_low = 0, last_low = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign scl_in = ~(scl_pull_low | hold);

  smb_scl_gen #(.FREE_OVF(FREE)) dut_i (
    .clk(clk), .rst(rst), .en(en), .mst_run(mst_run), .free_to_en(free_to_en),
    .slv_inhibit(slv_inhibit), .src_sel(src_sel), .ovf_src(ovf_src),
    .scl_in(scl_in), .start_det(start_det), .slv_evt(slv_evt),
    .scl_pull_low(scl_pull_low), .bit_strobe(bit_strobe), .bus_free(bus_free),
    .slv_evt_out(slv_evt_out), .addr_nack(addr_nack)
  );

  function automatic int exp_bit(input int p, input int stretch);
    return (stretch != 0) ? 4 * p : 3 * p;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ncyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_strobes(input int n);
    int target = nstb + n;
    while (nstb < target) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // overflow strobe generators
  initial begin
    forever begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        if (oc[i] >= per[i] - 1) begin oc[i] = 0; ovf_src[i] = 1'b1; end
        else begin oc[i] = oc[i] + 1; ovf_src[i] = 1'b0; end
      end
    end
  end

  // output monitor, sampled between edges
  initial begin
    forever begin
      @(posedge clk);
      #5;
      cyc++;
      if (bit_strobe) begin prev_stb = last_stb; last_stb = cyc; nstb++; end
      if (scl_pull_low) run_low++;
      else if (run_low > 0) begin last_low = run_low; run_low = 0; end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int p, s, ns;
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) begin
      per[i] = 10 + int'($urandom % 11);
      oc[i] = 0;
    end
    ncyc(4);
    rst = 1'b0;
    @(negedge clk);
    check(!scl_pull_low && !bit_strobe && !bus_free && !slv_evt_out && !addr_nack,
          "reset", int'(scl_pull_low), 0);
    en = 1'b1;

    // R7: overflows ignored when idle and timeout disabled
    ncyc(100);
    check(!scl_pull_low && !bus_free, "R7", int'(scl_pull_low | bus_free), 0);

    // R1 R2 R3: each source, then random picks
    for (int k = 0; k < 10; k++) begin
      s = (k < 4) ? k : int'($urandom % 4);
      p = per[s];
      src_sel = 2'(s);
      mst_run = 1'b1;
      wait_strobes(3);
      check(last_stb - prev_stb == exp_bit(p, 0), "R1 R3 bit period",
            last_stb - prev_stb, exp_bit(p, 0));
      check(last_low == p, "R2 low time", last_low, p);
      mst_run = 1'b0;
      ncyc(4 * p + 10);
    end

    // R4: stretching
    s = 1; p = per[s]; src_sel = 2'(s);
    mst_run = 1'b1;
    wait_strobes(2);
    hold = 1'b1;
    while (scl_pull_low) @(negedge clk);
    ncyc(p + p / 2);
    hold = 1'b0;
    wait_strobes(1);
    check(last_stb - prev_stb == exp_bit(p, 1), "R4 stretched period",
          last_stb - prev_stb, exp_bit(p, 1));

    // R5: contention in the high phase
    wait_strobes(1);
    while (scl_pull_low) @(negedge clk);
    ncyc(p + p / 2);
    ns = nstb;
    hold = 1'b1;
    ncyc(5);
    check(scl_pull_low == 1'b1, "R5 pull-low on contention", int'(scl_pull_low), 1);
    check(nstb == ns, "R5 no strobe on contention", nstb - ns, 0);
    hold = 1'b0;

    // R6: strobe width
    wait_strobes(1);
    @(negedge clk);
    check(!bit_strobe && scl_pull_low, "R6 one-cycle strobe", int'(bit_strobe), 0);

    // R12: stop at end of bit
    mst_run = 1'b0;
    ns = nstb;
    ncyc(6 * p);
    check(nstb == ns && !scl_pull_low, "R12 stop idle", nstb - ns, 0);

    // R9: disable mid low
    mst_run = 1'b1;
    wait_strobes(1);
    en = 1'b0;
    @(negedge clk);
    check(!scl_pull_low && !bit_strobe, "R9 release on disable", int'(scl_pull_low), 0);
    mst_run = 1'b0;
    ncyc(3 * p);
    check(!scl_pull_low, "R9 stays idle", int'(scl_pull_low), 0);
    en = 1'b1;

    // R8: free-bus timeout
    ncyc(4 * p);
    free_to_en = 1'b1;
    ncyc((FREE - 1) * p - 2);
    check(!bus_free, "R8 not yet free", int'(bus_free), 0);
    ncyc(3 * p);
    check(bus_free == 1'b1, "R8 free set", int'(bus_free), 1);
    hold = 1'b1;
    ncyc(4);
    check(!bus_free, "R8 free cleared by low line", int'(bus_free), 0);
    hold = 1'b0;
    free_to_en = 1'b0;

    // R10 R11: slave inhibit gating
    slv_inhibit = 1'b1;
    slv_evt = 1'b1; @(negedge clk); slv_evt = 1'b0; @(negedge clk);
    check(slv_evt_out == 1'b0, "R10 registered one cycle", int'(slv_evt_out), 0);
    slv_evt = 1'b1; @(negedge clk);
    check(slv_evt_out == 1'b1, "R10 event before START passes", int'(slv_evt_out), 1);
    slv_evt = 1'b0;
    start_det = 1'b1; @(negedge clk); start_det = 1'b0;
    check(addr_nack == 1'b1, "R11 nack after START", int'(addr_nack), 1);
    slv_evt = 1'b1; @(negedge clk); slv_evt = 1'b0;
    check(slv_evt_out == 1'b0, "R10 event blocked", int'(slv_evt_out), 0);
    slv_inhibit = 1'b0;
    ncyc(3);
    check(addr_nack == 1'b1, "R11 nack held until START", int'(addr_nack), 1);
    start_det = 1'b1; @(negedge clk); start_det = 1'b0;
    check(addr_nack == 1'b0, "R11 nack cleared", int'(addr_nack), 0);
    slv_evt = 1'b1; @(negedge clk); slv_evt = 1'b0;
    check(slv_evt_out == 1'b1, "R10 event passes again", int'(slv_evt_out), 1);
    en = 1'b0;
    slv_evt = 1'b1; @(negedge clk); slv_evt = 1'b0;
    check(slv_evt_out == 1'b0, "R9 no events when disabled", int'(slv_evt_out), 0);

    done = 1'b1;
    finish_run();
  end
endmodule